// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked system use an external asynchronous static RAM of 512K bytes. A client hands it one access at a time over a valid/ready handshake. Each access is a read or a write, with a 19-bit address and, for writes, an 8-bit data byte. The block then drives the memory's active-low chip select, write enable and output enable, together with the address and its own data driver, in an order that keeps the memory's access and pulse-width minimums. Read data comes back on a one-cycle valid strobe.

The length of each phase is set in whole clock periods. `READ_CYCLES` sets how long the output enable is held low for a read. `WE_PULSE_CYCLES` sets the width of the write pulse. `TURNAROUND_CYCLES` sets the quiet gap after every access. The defaults suit a 4 ns clock and the fastest memory grade: a 12 ns read window covers the 10 ns access time, and an 8 ns write pulse covers both the pulse minimum and the 6 ns data setup.

A write never lowers output enable, so the write pulse never has to absorb the memory's output turn-off time. Between accesses the chip is deselected, which puts it in its low-power standby state.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Whenever `req_ready` is 1, the chip is deselected: `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1 and `mem_dq_oe` is 0.
- R3: A read (`req_write`=0) holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly `READ_CYCLES` cycles, starting on the edge that accepts the request. `mem_dq_i` is captured on the edge that ends this window, and the captured byte is the one stored at the requested address.
- R4: Each read produces exactly one `rsp_valid` pulse, one cycle wide, carrying the read byte on `rsp_rdata`. The pulse appears `READ_CYCLES` edges after the accepting edge.
- R5: A write (`req_write`=1) holds `mem_cs_n`=0 and `mem_we_n`=0 for exactly `WE_PULSE_CYCLES` cycles, with `mem_dq_oe`=1 and `mem_dq_o` equal to the request data for the whole pulse. Chip select, write enable and the driver are all released on the same edge, and the byte is then stored at the requested address.
- R6: `mem_oe_n` is 1 whenever `mem_we_n` is 0 or `mem_dq_oe` is 1. The controller and the memory never drive the data bus at the same time.
- R7: Every access is followed by `TURNAROUND_CYCLES` cycles with all strobes inactive. `mem_oe_n` never falls in the cycle right after `mem_dq_oe` was 1.
- R8: `req_ready` drops on the accepting edge and stays 0 until the access and its turnaround are over. A `req_valid` seen while `req_ready` is 0 has no effect, and `mem_addr` is stable while `mem_cs_n` is 0.
- R9: `req_ready` returns `READ_CYCLES`+`TURNAROUND_CYCLES` edges after a read is accepted, and `WE_PULSE_CYCLES`+`TURNAROUND_CYCLES` edges after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | 8 | Data read from memory bus |

## Verification
All the strobes are registered from one phase register, so a wrong phase shows up at the ports on the edge right after it goes wrong. It appears as a strobe combination that breaks the truth table, or as a ready signal that disagrees with the strobes. A phase timer that runs short or long changes the width of the chip-select window. The bench's memory model catches this within one access: a read closed early returns the model's not-yet-valid byte, and a write of the wrong width reports its measured length. A lost or stale address latch shows up only later, when a read of that location returns the wrong byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } held_t;

    held_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.addr  = in_addr;
            st_d.wdata = in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_addr  = st_q.addr;
    assign held_wdata = st_q.wdata;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int DATA_W            = 8,
    parameter int CNT_W             = 2,
    parameter int READ_CYCLES       = 3,
    parameter int WE_PULSE_CYCLES   = 2,
    parameter int TURNAROUND_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    output logic              req_ready,
    output logic              take,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cs_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              dq_oe,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYCLES - 1);
    localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TURNAROUND_CYCLES - 1);

    typedef struct packed {
        phase_e            phase;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        phase:  PH_IDLE,
        cs_n:   1'b1,
        we_n:   1'b1,
        oe_n:   1'b1,
        dq_oe:  1'b0,
        rvalid: 1'b0,
        rdata:  '0
    };

    seq_t st_d, st_q;

    assign req_ready = (st_q.phase == PH_IDLE);
    assign take      = req_valid && req_ready;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (take) begin
                    tmr_load  = 1'b1;
                    st_d.cs_n = 1'b0;
                    if (req_write) begin
                        st_d.phase = PH_WRITE;
                        st_d.we_n  = 1'b0;
                        st_d.oe_n  = 1'b1;
                        st_d.dq_oe = 1'b1;
                        tmr_val    = WE_LAST;
                    end else begin
                        st_d.phase = PH_READ;
                        st_d.oe_n  = 1'b0;
                        st_d.we_n  = 1'b1;
                        tmr_val    = RD_LAST;
                    end
                end
            end
            PH_READ: begin
                if (tmr_expired) begin
                    st_d.rdata  = dq_in;
                    st_d.rvalid = 1'b1;
                    st_d.cs_n   = 1'b1;
                    st_d.oe_n   = 1'b1;
                    st_d.phase  = PH_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = TA_LAST;
                end
            end
            PH_WRITE: begin
                if (tmr_expired) begin
                    st_d.cs_n  = 1'b1;
                    st_d.we_n  = 1'b1;
                    st_d.dq_oe = 1'b0;
                    st_d.phase = PH_GAP;
                    tmr_load   = 1'b1;
                    tmr_val    = TA_LAST;
                end
            end
            PH_GAP: begin
                if (tmr_expired) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n   = st_q.cs_n;
    assign we_n   = st_q.we_n;
    assign oe_n   = st_q.oe_n;
    assign dq_oe  = st_q.dq_oe;
    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W            = 19,
    parameter int DATA_W            = 8,
    parameter int READ_CYCLES       = 3,
    parameter int WE_PULSE_CYCLES   = 2,
    parameter int TURNAROUND_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int MAX_CYC = max3(READ_CYCLES, WE_PULSE_CYCLES, TURNAROUND_CYCLES);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             take;
    logic             tmr_load;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .held_addr  (mem_addr),
        .held_wdata (mem_dq_o)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_fsm #(
        .DATA_W            (DATA_W),
        .CNT_W             (CNT_W),
        .READ_CYCLES       (READ_CYCLES),
        .WE_PULSE_CYCLES   (WE_PULSE_CYCLES),
        .TURNAROUND_CYCLES (TURNAROUND_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_ready   (req_ready),
        .take        (take),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .dq_in       (mem_dq_i),
        .cs_n        (mem_cs_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_oe       (mem_dq_oe),
        .rvalid      (rsp_valid),
        .rdata       (rsp_rdata)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n && !mem_dq_oe)); // R3

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

    AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe)); // R5

    AST_DRIVE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R6

    AST_OE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R8

endmodule

bind sram_seq_ctrl sram_ctl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;

    localparam int RD = 3;
    localparam int WP = 2;
    localparam int TA = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_o;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_i = 8'hEE;

    always #2 clk = ~clk;

    sram_seq_ctrl #(
        .READ_CYCLES       (RD),
        .WE_PULSE_CYCLES   (WP),
        .TURNAROUND_CYCLES (TA)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] seed(input logic [18:0] a);
        return a[7:0] ^ {1'b0, a[18:12]} ^ 8'h5A;
    endfunction

    // memory model and bench reference are kept apart
    logic [7:0] model_mem [logic [18:0]];
    logic [7:0] ref_mem   [logic [18:0]];

    function automatic logic [7:0] model_get(input logic [18:0] a);
        return model_mem.exists(a) ? model_mem[a] : seed(a);
    endfunction

    function automatic logic [7:0] ref_get(input logic [18:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : seed(a);
    endfunction

    int          rcnt = 0;
    int          wcnt = 0;
    logic [18:0] waddr = '0;
    logic [7:0]  wdat = '0;
    bit          prev_drive = 1'b0;
    int          contend = 0;
    int          gap_viol = 0;
    int          oe_in_write = 0;
    int          idle_viol = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            // read side: data valid only from the third selected cycle on
            if (!mem_cs_n && !mem_oe_n) begin
                rcnt <= rcnt + 1;
                mem_dq_i <= (rcnt + 1 >= 2) ? model_get(mem_addr) : 8'hEE;
            end else begin
                if (rcnt != 0) chk(rcnt == RD, "R3 read window width", rcnt, RD);
                rcnt <= 0;
                mem_dq_i <= 8'hEE;
            end
            // write side: committed when chip select or write enable rises
            if (!mem_cs_n && !mem_we_n) begin
                wcnt  <= wcnt + 1;
                waddr <= mem_addr;
                wdat  <= mem_dq_oe ? mem_dq_o : 8'hEE;
                if (!mem_oe_n) oe_in_write++;
            end else if (wcnt != 0) begin
                model_mem[waddr] = wdat;
                chk(wcnt == WP, "R5 write pulse width", wcnt, WP);
                wcnt <= 0;
            end
            if (!mem_oe_n && mem_dq_oe) contend++;
            if (!mem_oe_n && prev_drive) gap_viol++;
            prev_drive <= mem_dq_oe;
        end
    end

    typedef struct {
        logic [7:0]  data;
        int          acc;
        logic [18:0] addr;
    } exp_t;
    exp_t exp_q[$];
    bit   prev_rv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready && !(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)) idle_viol++;
            if (rsp_valid) begin
                chk(!prev_rv, "R4 strobe one cycle", 32'(prev_rv), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected response", rsp_rdata, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e.data, "R3 read data", rsp_rdata, e.data);
                    chk(cyc - e.acc == RD, "R4 response latency", cyc - e.acc, RD);
                end
            end
            prev_rv <= rsp_valid;
        end
    end

    // called at a falling edge; returns at a falling edge with ready high
    task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit junk);
        int acc;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        if (wr) ref_mem[a] = d;
        else exp_q.push_back('{ref_get(a), acc, a});
        if (junk) begin
            // R8: requests while busy must be ignored
            req_write = 1'b1; req_addr = a ^ 19'h1; req_wdata = ~d;
            chk(!req_ready, "R8 busy after accept", 32'(req_ready), 0);
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        chk(cyc - acc == (wr ? WP + TA : RD + TA), "R9 ready return", cyc - acc,
            wr ? WP + TA : RD + TA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && req_ready,
            "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid, req_ready},
            6'b111001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
            "R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);

        access(1'b0, 19'h00000, 8'h00, 1'b0);      // R3 unwritten location
        access(1'b1, 19'h00000, 8'hA5, 1'b0);      // R5
        access(1'b0, 19'h00000, 8'h00, 1'b0);
        access(1'b1, 19'h7FFFF, 8'hFF, 1'b0);      // top address
        access(1'b1, 19'h00001, 8'h00, 1'b0);
        access(1'b0, 19'h7FFFF, 8'h00, 1'b0);
        access(1'b0, 19'h00001, 8'h00, 1'b0);
        for (int i = 0; i < 24; i++) begin
            access(1'b1, 19'(i * 19'h2AB3 + 7), 8'(i * 37 + 3), 1'b0);
        end
        for (int i = 23; i >= 0; i--) begin
            access(1'b0, 19'(i * 19'h2AB3 + 7), 8'h00, 1'b0);
        end
        // back-to-back write then read of the same byte, and read then write
        access(1'b1, 19'h12345, 8'h3C, 1'b0);
        access(1'b0, 19'h12345, 8'h00, 1'b0);
        access(1'b1, 19'h12345, 8'hC3, 1'b0);
        access(1'b0, 19'h12345, 8'h00, 1'b0);
        // R8: junk requests while busy leave the neighbour untouched
        access(1'b0, 19'h40000, 8'h77, 1'b1);
        access(1'b1, 19'h40002, 8'h99, 1'b1);
        access(1'b0, 19'h40001, 8'h00, 1'b0);
        access(1'b0, 19'h40003, 8'h00, 1'b0);
        access(1'b0, 19'h40002, 8'h00, 1'b0);

        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
        chk(idle_viol == 0, "R2 deselected while ready", idle_viol, 0);
        chk(contend == 0, "R6 bus contention", contend, 0);
        chk(oe_in_write == 0, "R6 output enable during write", oe_in_write, 0);
        chk(gap_viol == 0, "R7 turnaround before output enable", gap_viol, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

endmodule